// File: doc/BRIEF.md
# Reference Divider Chain

This block turns a single oscillator clock into three timing signals. Two are loop reference strobes: single-cycle pulses at a programmed fraction of the oscillator rate. The third is a slow clock for a companion microcontroller. The main strobe comes from a 12-bit programmable counter followed by a fixed post-divider. That post-divider can be set to pass every pulse, every fourth pulse or every twenty-fifth pulse. The auxiliary strobe comes from a separate 14-bit programmable counter. The microcontroller clock is the oscillator divided by three or by four.

A standby input stops both reference counters, clears them and holds both strobes low. The microcontroller clock keeps running in standby, and only its own disable input stops it. Ratios below the smallest supported value are raised to that value. A change of post-divider setting restarts the main chain, so the main strobe never shows a shortened period at the moment of the switch.

Top module: `refdiv_chain`

## Requirements
- R1: With the post-divider passing every pulse, main_ref pulses once every max(main_ratio, 13) oscillator cycles, for any main_ratio up to 4095.
- R2: A main_ratio or aux_ratio value below 13, including 0, gives the same period as a value of 13.
- R3: post_sel selects the post-divide factor R: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 25, and 2'b11 gives 1. main_ref then repeats every N×R cycles, where N is the effective main ratio.
- R4: aux_ref pulses once every max(aux_ratio, 13) cycles, for any aux_ratio up to 16383, and does not depend on post_sel.
- R5: Every main_ref and aux_ref pulse is exactly one oscillator cycle wide.
- R6: When post_sel changes, the main chain restarts. The first clock edge that sees the new value counts as edge 1, and the next main_ref pulse follows edge N×R. No pulse is produced in between.
- R7: While standby is 1, main_ref and aux_ref stay low and both counters are cleared. After standby is released, the first main_ref pulse follows edge N×R−1 and the first aux_ref pulse follows edge A−1, where A is the effective auxiliary ratio.
- R8: With mcu_div4 = 0, mcu_clk has a period of 3 cycles and is high for 1 of them. With mcu_div4 = 1, it has a period of 4 cycles and is high for 2.
- R9: mcu_clk keeps its period while standby is 1. From the second cycle after mcu_off is set to 1, mcu_clk stays low.
- R10: While rst_n is low, main_ref, aux_ref and mcu_clk are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Stops and clears both reference counters |
| mcu_off | input | 1 | Stops the microcontroller clock |
| main_ratio | input | 12 | Main counter ratio (13 to 4095) |
| aux_ratio | input | 14 | Auxiliary counter ratio (13 to 16383) |
| post_sel | input | 2 | Post-divide select: 00 gives /1, 01 gives /4, 10 gives /25, 11 gives /1 |
| mcu_div4 | input | 1 | 1 divides the MCU clock by 4, 0 divides it by 3 |
| main_ref | output | 1 | Main reference strobe |
| aux_ref | output | 1 | Auxiliary reference strobe |
| mcu_clk | output | 1 | Microcontroller clock |

## Verification
The hardest case to reach from the ports is the restart on a post-divider change. It only shows if the switch lands while the post-divider holds a partial count, so that a chain without the restart would give a short first period. The stimulus first locks onto a main_ref pulse under one setting. It then switches at an arbitrary later cycle and counts the edges to the next pulse. This is repeated across all three factors, so an early or missing pulse shows up as a wrong count. Standby release is checked the same way, with edge counts taken from the release cycle for both strobes at once.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int unsigned MIN_RATIO = 13;

  typedef enum logic [1:0] {
    POST_BY1  = 2'b00,
    POST_BY4  = 2'b01,
    POST_BY25 = 2'b10,
    POST_RSVD = 2'b11
  } post_sel_e;

  localparam int unsigned POST_CNT_W = 5;

  function automatic logic [POST_CNT_W-1:0] post_factor(input post_sel_e s);
    case (s)
      POST_BY4:  post_factor = POST_CNT_W'(4);
      POST_BY25: post_factor = POST_CNT_W'(25);
      default:   post_factor = POST_CNT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/refdiv_prog_counter.sv
module refdiv_prog_counter #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned FLOOR = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [WIDTH-1:0] ratio,
  output logic             pulse
);

  localparam logic [WIDTH-1:0] FLOOR_V = WIDTH'(FLOOR);

  logic [WIDTH-1:0] cnt_q, cnt_d, eff, last;
  logic             at_end, cnt_en;

  always_comb begin
    eff    = (ratio < FLOOR_V) ? FLOOR_V : ratio;
    last   = eff - 1'b1;
    at_end = (cnt_q >= last);
    pulse  = at_end && run && !restart;
    if (!run || restart || at_end) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
    cnt_en = run || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: a strobe never lasts two cycles
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R7: a stopped counter is cleared at the next edge
  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/refdiv_post_div.sv
module refdiv_post_div
  import refdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      restart,
  input  post_sel_e sel,
  input  logic      in_pulse,
  output logic      out_pulse
);

  logic [POST_CNT_W-1:0] pcnt_q, pcnt_d, factor;
  logic                  pcnt_en, wrap;

  always_comb begin
    factor    = post_factor(sel);
    wrap      = (pcnt_q >= factor - 1'b1);
    out_pulse = in_pulse && wrap;
    pcnt_en   = !run || restart || in_pulse;
    if (!run || restart) pcnt_d = '0;
    else if (wrap)       pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  // R3: the pulse count stays below the largest factor
  p_post_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < POST_CNT_W'(25));

  // R6: a restart leaves the post-divider empty
  p_restart_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt_q == '0));

endmodule

// File: rtl/refdiv_mcu_clk.sv
module refdiv_mcu_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  input  logic div4,
  output logic mcu_clk
);

  logic [1:0] ph_q, ph_d, last;
  logic       hi, clk_d;

  always_comb begin
    last  = div4 ? 2'd3 : 2'd2;
    if (off || ph_q >= last) ph_d = 2'd0;
    else                     ph_d = ph_q + 2'd1;
    hi    = div4 ? (ph_q < 2'd2) : (ph_q == 2'd0);
    clk_d = hi && !off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= 2'd0;
      mcu_clk <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      mcu_clk <= clk_d;
    end
  end

  // R8: divide-by-3 high time is a single cycle
  p_div3_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!div4 && $stable(div4) && mcu_clk) |=> !mcu_clk);

  // R9: a disabled clock goes low at the next edge
  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !mcu_clk);

endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain
  import refdiv_pkg::*;
#(
  parameter int unsigned MAIN_W = 12,
  parameter int unsigned AUX_W  = 14
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              mcu_off,
  input  logic [MAIN_W-1:0] main_ratio,
  input  logic [AUX_W-1:0]  aux_ratio,
  input  logic [1:0]        post_sel,
  input  logic              mcu_div4,
  output logic              main_ref,
  output logic              aux_ref,
  output logic              mcu_clk
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  post_sel_e  sel_now, sel_q;
  logic       run, restart, sel_en, main_tc;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_comb begin
    sel_now = post_sel_e'(post_sel);
    run     = !standby;
    sel_en  = (sel_now != sel_q);
    restart = run && sel_en;
  end

  always_ff @(posedge clk_osc or negedge rst_i_n) begin
    if (!rst_i_n)    sel_q <= POST_BY1;
    else if (sel_en) sel_q <= sel_now;
  end

  refdiv_prog_counter #(.WIDTH(MAIN_W), .FLOOR(MIN_RATIO)) u_main_cnt (
    .clk(clk_osc), .rst_n(rst_i_n), .run(run), .restart(restart),
    .ratio(main_ratio), .pulse(main_tc)
  );

  refdiv_post_div u_post (
    .clk(clk_osc), .rst_n(rst_i_n), .run(run), .restart(restart),
    .sel(sel_now), .in_pulse(main_tc), .out_pulse(main_ref)
  );

  refdiv_prog_counter #(.WIDTH(AUX_W), .FLOOR(MIN_RATIO)) u_aux_cnt (
    .clk(clk_osc), .rst_n(rst_i_n), .run(run), .restart(1'b0),
    .ratio(aux_ratio), .pulse(aux_ref)
  );

  refdiv_mcu_clk u_mcu (
    .clk(clk_osc), .rst_n(rst_i_n), .off(mcu_off), .div4(mcu_div4),
    .mcu_clk(mcu_clk)
  );

  // R7: no reference strobe while in standby
  p_standby_quiet_r7: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    standby |-> (!main_ref && !aux_ref));

endmodule

// File: tb/refdiv_chain_tb.sv
module refdiv_chain_tb;

  logic        clk = 1'b0;
  logic        rst_n, standby, mcu_off, mcu_div4;
  logic [11:0] main_ratio;
  logic [13:0] aux_ratio;
  logic [1:0]  post_sel;
  logic        main_ref, aux_ref, mcu_clk;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  refdiv_chain u_dut (
    .clk_osc(clk), .rst_n(rst_n), .standby(standby), .mcu_off(mcu_off),
    .main_ratio(main_ratio), .aux_ratio(aux_ratio), .post_sel(post_sel),
    .mcu_div4(mcu_div4), .main_ref(main_ref), .aux_ref(aux_ref),
    .mcu_clk(mcu_clk)
  );

  typedef struct packed {
    logic [11:0] m;
    logic [13:0] a;
    logic [1:0]  s;
    logic [31:0] em;
    logic [31:0] ea;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{12'd13,   14'd13,    2'b00, 32'd13,   32'd13},    // R1 R4 minimum
    '{12'd100,  14'd200,   2'b00, 32'd100,  32'd200},   // R1 R4
    '{12'd5,    14'd2,     2'b00, 32'd13,   32'd13},    // R2
    '{12'd0,    14'd0,     2'b00, 32'd13,   32'd13},    // R2 zero
    '{12'd20,   14'd50,    2'b01, 32'd80,   32'd50},    // R3 by 4
    '{12'd20,   14'd13,    2'b10, 32'd500,  32'd13},    // R3 by 25
    '{12'd30,   14'd40,    2'b11, 32'd30,   32'd40},    // R3 reserved
    '{12'd4095, 14'd16383, 2'b00, 32'd4095, 32'd16383}  // R1 R4 maximum
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int w);
    return (w == 0) ? main_ref : aux_ref;
  endfunction

  // waits for a strobe, then counts cycles to the next one
  task automatic measure(input int w, output int per, output int wide);
    int k = 0;
    wide = 0;
    while (!pick(w) && k < 40000) begin @(negedge clk); k++; end
    per = 0;
    do begin
      @(negedge clk); per++;
      if (per == 1 && pick(w)) wide = 1;
    end while (!pick(w) && per < 40000);
  endtask

  task automatic wait_mcu_rise();
    logic prev = mcu_clk;
    int k = 0;
    do begin prev = mcu_clk; @(negedge clk); k++; end
    while (!(mcu_clk && !prev) && k < 50);
  endtask

  task automatic measure_mcu(output int per, output int hi);
    logic prev = 1'b0;
    wait_mcu_rise();
    per = 0; hi = 0;
    while (per < 20) begin
      if (per > 0 && mcu_clk && !prev) break;
      if (mcu_clk) hi++;
      per++;
      prev = mcu_clk;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main_seq
    int per, wide, hi, fm, fa, highs;
    rst_n = 1'b0; standby = 1'b0; mcu_off = 1'b0; mcu_div4 = 1'b0;
    main_ratio = 12'd13; aux_ratio = 14'd13; post_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {29'd0, main_ref, aux_ref, mcu_clk}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      main_ratio = VEC[i].m; aux_ratio = VEC[i].a; post_sel = VEC[i].s;
      measure(0, per, wide);            // first period may be partial
      measure(0, per, wide);
      check("R1/R2/R3 main period", per, int'(VEC[i].em));
      check("R5 main width", wide, 0);
      measure(1, per, wide);
      measure(1, per, wide);
      check("R4/R2 aux period", per, int'(VEC[i].ea));
      check("R5 aux width", wide, 0);
    end

    // R6 restart on post-divide change
    main_ratio = 12'd13; aux_ratio = 14'd15; post_sel = 2'b00;
    measure(0, per, wide);
    repeat (5) @(negedge clk);
    post_sel = 2'b01;
    per = 0;
    do begin @(negedge clk); per++; end while (!main_ref && per < 2000);
    check("R6 switch to by 4", per, 52);
    repeat (7) @(negedge clk);
    post_sel = 2'b10;
    per = 0;
    do begin @(negedge clk); per++; end while (!main_ref && per < 2000);
    check("R6 switch to by 25", per, 325);
    repeat (3) @(negedge clk);
    post_sel = 2'b00;
    per = 0;
    do begin @(negedge clk); per++; end while (!main_ref && per < 2000);
    check("R6 switch to by 1", per, 13);

    // R7 standby quiets strobes, R9 mcu clock keeps running
    standby = 1'b1;
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (main_ref || aux_ref) highs++;
    end
    check("R7 strobes low in standby", highs, 0);
    measure_mcu(per, hi);
    check("R9 mcu period in standby", per, 3);
    @(negedge clk);
    standby = 1'b0;
    fm = 0; fa = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (main_ref && fm == 0) fm = i;
      if (aux_ref && fa == 0) fa = i;
    end
    check("R7 main first pulse after release", fm, 12);
    check("R7 aux first pulse after release", fa, 14);

    // R8 mcu clock divide settings
    mcu_div4 = 1'b0;
    repeat (8) @(negedge clk);
    measure_mcu(per, hi);
    check("R8 div3 period", per, 3);
    check("R8 div3 high time", hi, 1);
    mcu_div4 = 1'b1;
    repeat (8) @(negedge clk);
    measure_mcu(per, hi);
    check("R8 div4 period", per, 4);
    check("R8 div4 high time", hi, 2);

    // R9 mcu_off holds the clock low
    mcu_off = 1'b1;
    repeat (2) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mcu_clk) highs++;
    end
    check("R9 mcu held low when off", highs, 0);
    mcu_off = 1'b0;
    repeat (6) @(negedge clk);
    measure_mcu(per, hi);
    check("R9 mcu resumes", per, 4);

    // R10 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 outputs in reset", {29'd0, main_ref, aux_ref, mcu_clk}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule